// File: doc/BRIEF.md
# Seven-Output Pulse Width Modulator with Source Select and Bypass

The block drives seven pulse-width-modulated outputs from five slow reference sources. Six outputs leave the block on an external bus and the seventh stays on chip as an internal signal. Software programs each channel through a small synchronous register bus. It picks a source index and sets the number of source cycles the output spends high and low. A gate bit starts and stops the channel. Instead of a waveform, a bypass bit can forward the chosen source level straight to the output.

The source inputs are level signals sampled in the system clock domain. Each rising edge of the selected source advances that channel's counters by one. A phase field value of N lasts N+1 source cycles, so every period is between 2 and 131072 source cycles. Count changes wait for the next period boundary. Source changes are refused while a channel runs, so software must clear the gate before it changes the source.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: After reset every register reads zero and all seven outputs are low.
- R2: Register map, 16-bit count fields. Address 0 holds the gate bits, channel c at bit c. Address 1 holds the 3-bit source field of channel c at bits 3c+2..3c and its bypass bit at bit 21+c. Address 2+c holds the high count of channel c, and address 9+c holds its low count. A read returns what was written, limited to the implemented bits.
- R3: While a channel's gate bit is clear, its output is low.
- R4: A gated, non-bypassed channel with high count H and low count W stays high for H+1 rising edges of its source and low for W+1. The shortest period is two source cycles.
- R5: A gated channel with its bypass bit set outputs the current level of its selected source.
- R6: A write to address 1 leaves the source field and the bypass bit of every gated channel unchanged and updates those of ungated channels.
- R7: A new high or low count written while a channel runs takes effect only at the start of the next period. The phase in progress keeps its old length.
- R8: The cycle after a channel's gate bit is set, its output is high and a fresh high phase begins.
- R9: Source values 0 to 4 select source inputs 0 to 4. Values 5 to 7 select no source: the counters never advance, and in bypass the output is low.
- R10: Channels 0 to 5 drive `pwm_ext` bits 0 to 5, and channel 6 drives `pwm_int`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_lvl | input | 5 | Reference source levels, synchronous to clk |
| pwm_ext | output | 6 | External channel outputs |
| pwm_int | output | 1 | Internal channel output |

## Verification
Some properties are checked on every cycle. Phase counters never pass their live limit. The live counts stay frozen through a running high phase. A channel sits at the start of its high phase the cycle after it was ungated. A write to address 1 never changes the source field or bypass bit of a gated channel. Other behaviour only the bench scenarios can show. These are the measured high and low lengths against the programmed counts across sources, the bypass output following its source, the deferred count update in the middle of a phase, and the dead source codes.

// File: rtl/pwm_pkg.sv
// Shared constants and types for the multichannel PWM.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_pkg;
    localparam int PWM_NCH  = 7;
    localparam int PWM_NSRC = 5;
    localparam int PWM_SELW = 3;
    localparam int PWM_CNTW = 16;
    localparam int PWM_DW   = 32;
    localparam int PWM_AW   = 4;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } pwm_phase_e;
endpackage

// File: rtl/pwm_src_edge.sv
// Detects rising edges on each reference source level.
// Assumes: the source levels are already synchronous to clk.
module pwm_src_edge #(
    parameter int NSRC = pwm_pkg::PWM_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    output logic [NSRC-1:0] src_rise
);
    logic [NSRC-1:0] src_q;

    // Keep the previous level of every source.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_lvl;
    end

    assign src_rise = src_lvl & ~src_q;
endmodule

// File: rtl/pwm_regs.sv
// Register file: gate bits, source fields and bypass bits, and per-channel
// high and low counts. Source fields and bypass bits of a gated channel
// are write-protected.
// Assumes: DW covers NCH*SELW+NCH bits, and the address space covers 2+2*NCH.
module pwm_regs #(
    parameter int NCH  = pwm_pkg::PWM_NCH,
    parameter int SELW = pwm_pkg::PWM_SELW,
    parameter int CNTW = pwm_pkg::PWM_CNTW,
    parameter int DW   = pwm_pkg::PWM_DW,
    parameter int AW   = pwm_pkg::PWM_AW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             bus_addr,
    input  logic                      bus_we,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic [NCH-1:0]            ch_en,
    output logic [NCH-1:0][SELW-1:0]  ch_sel,
    output logic [NCH-1:0]            ch_byp,
    output logic [NCH-1:0][CNTW-1:0]  ch_hold,
    output logic [NCH-1:0][CNTW-1:0]  ch_wait
);
    localparam int BYP_BASE  = NCH * SELW;
    localparam int HOLD_BASE = 2;
    localparam int WAIT_BASE = 2 + NCH;
    localparam logic [AW-1:0] A_EN  = AW'(0);
    localparam logic [AW-1:0] A_SEL = AW'(1);

    logic [NCH-1:0]           en_q;
    logic [NCH-1:0][SELW-1:0] sel_q;
    logic [NCH-1:0]           byp_q;
    logic [NCH-1:0][CNTW-1:0] hold_q;
    logic [NCH-1:0][CNTW-1:0] wait_q;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DW-1:BYP_BASE+NCH];

    // Gate register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         en_q <= '0;
        else if (bus_we && bus_addr == A_EN) en_q <= bus_wdata[NCH-1:0];
    end

    // Source, bypass and count writes; source and bypass only for ungated channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            byp_q  <= '0;
            hold_q <= '0;
            wait_q <= '0;
        end else if (bus_we) begin
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == A_SEL && !en_q[c]) begin
                    sel_q[c] <= bus_wdata[c*SELW +: SELW];
                    byp_q[c] <= bus_wdata[BYP_BASE + c];
                end
                if (bus_addr == AW'(HOLD_BASE + c)) hold_q[c] <= bus_wdata[CNTW-1:0];
                if (bus_addr == AW'(WAIT_BASE + c)) wait_q[c] <= bus_wdata[CNTW-1:0];
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_EN) begin
            bus_rdata[NCH-1:0] = en_q;
        end else if (bus_addr == A_SEL) begin
            bus_rdata[BYP_BASE-1:0]   = sel_q;
            bus_rdata[BYP_BASE +: NCH] = byp_q;
        end
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(HOLD_BASE + c)) bus_rdata[CNTW-1:0] = hold_q[c];
            if (bus_addr == AW'(WAIT_BASE + c)) bus_rdata[CNTW-1:0] = wait_q[c];
        end
    end

    assign ch_en   = en_q;
    assign ch_sel  = sel_q;
    assign ch_byp  = byp_q;
    assign ch_hold = hold_q;
    assign ch_wait = wait_q;

    // Write protection of running channels' source and bypass.
    for (genvar g = 0; g < NCH; g++) begin : g_lock
        p_sel_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_SEL && en_q[g]) |=> ($stable(sel_q[g]) && $stable(byp_q[g])));
    end
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: picks a source, counts its rising edges through a high
// phase of hold+1 and a low phase of wait+1 edges, and reloads the counts
// only at a period boundary. Bypass forwards the source level.
// Assumes: source levels and edges are synchronous to clk.
module pwm_chan #(
    parameter int NSRC = pwm_pkg::PWM_NSRC,
    parameter int SELW = pwm_pkg::PWM_SELW,
    parameter int CNTW = pwm_pkg::PWM_CNTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SELW-1:0] sel,
    input  logic            byp,
    input  logic [CNTW-1:0] hold_cfg,
    input  logic [CNTW-1:0] wait_cfg,
    input  logic [NSRC-1:0] src_lvl,
    input  logic [NSRC-1:0] src_rise,
    output logic            ch_out
);
    import pwm_pkg::*;

    pwm_phase_e      phase;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] live_hold;
    logic [CNTW-1:0] live_wait;
    logic            sel_lvl;
    logic            sel_tick;

    // Source multiplexer; codes with no source give a dead input.
    always_comb begin
        sel_lvl  = 1'b0;
        sel_tick = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (sel == SELW'(s)) begin
                sel_lvl  = src_lvl[s];
                sel_tick = src_rise[s];
            end
        end
    end

    // Phase counter with period-boundary reload of the live counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_HIGH;
            cnt       <= '0;
            live_hold <= '0;
            live_wait <= '0;
        end else if (!en || byp) begin
            phase     <= PH_HIGH;
            cnt       <= '0;
            live_hold <= hold_cfg;
            live_wait <= wait_cfg;
        end else if (sel_tick) begin
            if (phase == PH_HIGH) begin
                if (cnt == live_hold) begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == live_wait) begin
                    phase     <= PH_HIGH;
                    cnt       <= '0;
                    live_hold <= hold_cfg;
                    live_wait <= wait_cfg;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign ch_out = en & (byp ? sel_lvl : (phase == PH_HIGH));

    p_cnt_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) |-> (cnt <= live_hold));
    p_cnt_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |-> (cnt <= live_wait));
    p_live_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !byp && phase == PH_HIGH) |=> ($stable(live_hold) && $stable(live_wait)));
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase == PH_HIGH && cnt == '0));
endmodule

// File: rtl/pwm_multi_ctrl.sv
// Top: register file, shared source edge detection and NCH channels.
// The last channel drives the internal output; the others are external.
// Assumes: single clock domain, source levels synchronous to clk.
module pwm_multi_ctrl #(
    parameter int NCH  = pwm_pkg::PWM_NCH,
    parameter int NSRC = pwm_pkg::PWM_NSRC,
    parameter int SELW = pwm_pkg::PWM_SELW,
    parameter int CNTW = pwm_pkg::PWM_CNTW,
    parameter int DW   = pwm_pkg::PWM_DW,
    parameter int AW   = pwm_pkg::PWM_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_lvl,
    output logic [NCH-2:0]  pwm_ext,
    output logic            pwm_int
);
    logic [NCH-1:0]           ch_en;
    logic [NCH-1:0][SELW-1:0] ch_sel;
    logic [NCH-1:0]           ch_byp;
    logic [NCH-1:0][CNTW-1:0] ch_hold;
    logic [NCH-1:0][CNTW-1:0] ch_wait;
    logic [NSRC-1:0]          src_rise;
    logic [NCH-1:0]           ch_out;

    pwm_src_edge #(.NSRC(NSRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .src_rise (src_rise)
    );

    pwm_regs #(.NCH(NCH), .SELW(SELW), .CNTW(CNTW), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_en     (ch_en),
        .ch_sel    (ch_sel),
        .ch_byp    (ch_byp),
        .ch_hold   (ch_hold),
        .ch_wait   (ch_wait)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(.NSRC(NSRC), .SELW(SELW), .CNTW(CNTW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[g]),
            .sel      (ch_sel[g]),
            .byp      (ch_byp[g]),
            .hold_cfg (ch_hold[g]),
            .wait_cfg (ch_wait[g]),
            .src_lvl  (src_lvl),
            .src_rise (src_rise),
            .ch_out   (ch_out[g])
        );
    end

    assign pwm_ext = ch_out[NCH-2:0];
    assign pwm_int = ch_out[NCH-1];
endmodule

// File: tb/tb_pwm_multi_ctrl.sv
module tb_pwm_multi_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  src = '0;
    logic [5:0]  pwm_ext;
    logic        pwm_int;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [6:0]  en_m = '0;
    logic [2:0]  sel_m [7];
    logic        byp_m [7];

    pwm_multi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src),
        .pwm_ext(pwm_ext), .pwm_int(pwm_int)
    );

    always #4 clk = ~clk;

    // Source s toggles every s+1 cycles: period 2*(s+1) clocks.
    int sc [5] = '{0, 0, 0, 0, 0};
    always @(negedge clk) begin
        for (int s = 0; s < 5; s++) begin
            if (sc[s] == s) begin
                sc[s] = 0;
                src[s] = ~src[s];
            end else begin
                sc[s] = sc[s] + 1;
            end
        end
    end

    function automatic int src_per(int s);
        return 2 * (s + 1);
    endfunction

    function automatic int exp_len(int n, int s);
        return (n + 1) * src_per(s);
    endfunction

    function automatic logic out_of(int ch);
        return (ch == 6) ? pwm_int : pwm_ext[ch];
    endfunction

    function automatic logic [31:0] sel_word();
        logic [31:0] w = '0;
        for (int c = 0; c < 7; c++) begin
            w[c*3 +: 3] = sel_m[c];
            w[21 + c]   = byp_m[c];
        end
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Ungate, program source and counts, gate again.
    task automatic cfg(int ch, int s, bit byp, int h, int w);
        en_m[ch] = 1'b0;
        wr(4'd0, {25'd0, en_m});
        sel_m[ch] = 3'(s);
        byp_m[ch] = byp;
        wr(4'd1, sel_word());
        wr(4'(2 + ch), 32'(h));
        wr(4'(9 + ch), 32'(w));
        en_m[ch] = 1'b1;
        wr(4'd0, {25'd0, en_m});
    endtask

    // Measure one full high and low phase, in clock cycles.
    task automatic meas(int ch, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        while (out_of(ch) !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (out_of(ch) !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (out_of(ch) === 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
        while (out_of(ch) === 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, lo, bad;
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 7; c++) begin sel_m[c] = '0; byp_m[c] = 1'b0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk("R1 reset register", d, 32'd0);
        end
        chk("R1 reset outputs", {25'd0, pwm_int, pwm_ext}, 32'd0);

        // R2: readback of counts and gate register
        for (int i = 0; i < 20; i++) begin
            int a = 2 + ($urandom % 14);
            logic [31:0] v = $urandom;
            wr(4'(a), v);
            rd(4'(a), d);
            chk("R2 count readback", d, {16'd0, v[15:0]});
        end
        wr(4'd5, 32'hFFFF);
        rd(4'd5, d);
        chk("R2 max count", d, 32'h0000FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, d);
        chk("R2 select readback", d, 32'h0FFF_FFFF);
        wr(4'd1, 32'd0);

        // R3: ungated channels stay low
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if ({pwm_int, pwm_ext} !== 7'd0) bad++;
        end
        chk("R3 ungated low", 32'(bad), 32'd0);

        // R4 / R10: directed minimum period, then random channels
        cfg(0, 0, 0, 0, 0);
        meas(0, hi, lo);
        chk("R4 min high", 32'(hi), 32'(exp_len(0, 0)));
        chk("R4 min low", 32'(lo), 32'(exp_len(0, 0)));
        cfg(6, 2, 0, 1, 2);
        meas(6, hi, lo);
        chk("R10 internal high", 32'(hi), 32'(exp_len(1, 2)));
        chk("R10 internal low", 32'(lo), 32'(exp_len(2, 2)));
        for (int i = 0; i < 10; i++) begin
            int ch = $urandom % 7;
            int s  = $urandom % 5;
            int h  = $urandom % 4;
            int w  = $urandom % 4;
            cfg(ch, s, 0, h, w);
            meas(ch, hi, lo);
            chk("R4 random high", 32'(hi), 32'(exp_len(h, s)));
            chk("R4 random low", 32'(lo), 32'(exp_len(w, s)));
        end

        // R5: bypass follows source 3
        cfg(2, 3, 1, 0, 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (pwm_ext[2] !== src[3]) bad++;
        end
        chk("R5 bypass follows source", 32'(bad), 32'd0);

        // R6: select write ignored for gated channel 1, applied to ungated channel 0
        cfg(1, 0, 0, 1, 1);
        en_m[0] = 1'b0;
        wr(4'd0, {25'd0, en_m});
        begin
            logic [31:0] w = sel_word();
            w[3 +: 3] = 3'd4;
            w[0 +: 3] = 3'd2;
            wr(4'd1, w);
        end
        sel_m[0] = 3'd2;
        rd(4'd1, d);
        chk("R6 gated field kept", {29'd0, d[5:3]}, 32'd0);
        chk("R6 ungated field written", {29'd0, d[2:0]}, 32'd2);
        meas(1, hi, lo);
        chk("R6 gated still on source 0", 32'(hi), 32'(exp_len(1, 0)));

        // R7: hold change in mid-phase waits for the boundary
        cfg(3, 1, 0, 2, 1);
        while (pwm_ext[3] !== 1'b0) @(negedge clk);
        while (pwm_ext[3] !== 1'b1) @(negedge clk);
        hi = 1;
        wr(4'd5, 32'd5);
        hi += 2;
        @(negedge clk);
        while (pwm_ext[3] === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (pwm_ext[3] === 1'b0) begin lo++; @(negedge clk); end
        chk("R7 current high keeps old count", 32'(hi), 32'(exp_len(2, 1)));
        chk("R7 low phase unchanged", 32'(lo), 32'(exp_len(1, 1)));
        hi = 0;
        while (pwm_ext[3] === 1'b1) begin hi++; @(negedge clk); end
        chk("R7 next high uses new count", 32'(hi), 32'(exp_len(5, 1)));

        // R3 / R8: ungate then regate starts in the high phase
        cfg(4, 4, 0, 3, 3);
        while (pwm_ext[4] !== 1'b0) @(negedge clk);
        en_m[4] = 1'b0;
        wr(4'd0, {25'd0, en_m});
        @(negedge clk);
        chk("R3 ungated output low", {31'd0, pwm_ext[4]}, 32'd0);
        en_m[4] = 1'b1;
        wr(4'd0, {25'd0, en_m});
        chk("R8 high right after gate", {31'd0, pwm_ext[4]}, 32'd1);
        meas(4, hi, lo);
        chk("R8 period after restart", 32'(hi + lo), 32'(exp_len(3, 4) + exp_len(3, 4)));

        // R9: dead source codes
        cfg(5, 6, 0, 0, 0);
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_ext[5] !== 1'b1) bad++;
        end
        chk("R9 dead source no counting", 32'(bad), 32'd0);
        cfg(5, 7, 1, 0, 0);
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #1;
            if (pwm_ext[5] !== 1'b0) bad++;
        end
        chk("R9 dead source bypass low", 32'(bad), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule